// File: doc/BRIEF.md
# Windowed Watchdog Monitor

This block catches runaway software by watching when software writes a service register. It measures each write against a free-running reference counter that advances on a count-enable tick. A write that comes too late is a fault. A write that comes too soon is also a fault, because a tight loop that keeps servicing the watchdog is as suspect as one that never does. Too late means the counter has wrapped twice since the last accepted write. Too soon means fewer than a minimum number of ticks have passed since that write.

On either fault the block raises a drive-low enable for an active-low, open-drain alarm line. That line can feed a reset or non-maskable interrupt input. The alarm stays latched until a system reset. A status bit records whether the fault was early or late. The external pad and the reset controller are outside the block.

Top module: `window_watchdog`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `alarmDrvLow` and `faultIsEarly` are 0. Reset also clears the reference counter, the overflow tally and the since-service count.
- R2: The reference counter is `CNT_W` bits wide. It advances by one on each clock edge where `cntEn` is 1, and idle cycles never move it. An overflow is a tick taken while the counter holds all ones, so it wraps to zero.
- R3: A late fault occurs on the edge that samples the `OVF_LIMIT`-th overflow (default 2) since the last accepted service write, or since reset if there has been none. From the next cycle `alarmDrvLow` is 1 and `faultIsEarly` is 0.
- R4: A service write is early when it arrives after fewer than `MIN_GAP` ticks since the last accepted service write. From the next cycle `alarmDrvLow` is 1 and `faultIsEarly` is 1. A write after exactly `MIN_GAP` ticks is accepted.
- R5: The first service write after reset is always accepted, whatever the elapsed count.
- R6: An accepted service write clears both the overflow tally and the since-service count. A tick in the same cycle as a service write is counted toward neither. An overflow in that cycle does not cause a late fault.
- R7: Once `alarmDrvLow` is 1 it stays 1 and `faultIsEarly` stays unchanged until reset. Later service writes and ticks have no effect on either output.
- R8: The service gap is measured in ticks only. Clock cycles with `cntEn` at 0 do not count toward `MIN_GAP`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serviceWr | input | 1 | One-cycle strobe: software wrote the service register |
| cntEn | input | 1 | Count enable (tick) for the reference counter |
| alarmDrvLow | output | 1 | 1 = pull the open-drain alarm line low; 0 = release it |
| faultIsEarly | output | 1 | Fault cause: 1 = early service, 0 = late; meaningful while the alarm is on |

## Verification
The bench builds the block with `CNT_W` = 4, `MIN_GAP` = 6 and `OVF_LIMIT` = 2. This makes a wrap take 16 ticks, so the two-overflow late window runs out after a few dozen ticks, and it puts the early-window boundary at six ticks. With these values the bench can reach both sides of the `MIN_GAP` boundary and late faults whose timing depends on the counter phase at the last service. It also covers an overflow that lands in the same cycle as a service write, and status that stays frozen across later overflows.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrWindow;   // accepted service: restart the window
    logic holdCount;   // alarm latched: freeze all counting
  } wdw_strobe_t;

endpackage

// File: rtl/wdw_datapath.sv
module wdw_datapath
  import wdw_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MIN_GAP   = 4096,
  parameter int OVF_LIMIT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cntEn,
  input  wdw_strobe_t strobe,
  output logic        lateHit,
  output logic        gapShort
);

  localparam int SINCE_W = $clog2(MIN_GAP + 1);
  localparam int TALLY_W = $clog2(OVF_LIMIT + 1);
  localparam logic [SINCE_W-1:0] GAP_Q      = SINCE_W'(MIN_GAP);
  localparam logic [TALLY_W-1:0] TALLY_LAST = TALLY_W'(OVF_LIMIT - 1);
  localparam logic [TALLY_W-1:0] TALLY_MAX  = TALLY_W'(OVF_LIMIT);

  logic [CNT_W-1:0]   refCnt;
  logic [TALLY_W-1:0] ovfTally;
  logic [SINCE_W-1:0] sinceCnt;
  logic               tickLive;
  logic               wrapTick;

  assign tickLive = cntEn && !strobe.holdCount;
  assign wrapTick = tickLive && (&refCnt);

  // Free-running reference counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0;
    end else if (tickLive) begin
      refCnt <= refCnt + 1'b1;
    end
  end

  // Overflows since last accepted service (saturating)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfTally <= '0;
    end else if (strobe.clrWindow) begin
      ovfTally <= '0;
    end else if (wrapTick && (ovfTally < TALLY_MAX)) begin
      ovfTally <= ovfTally + 1'b1;
    end
  end

  // Ticks since last accepted service (saturating at MIN_GAP)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceCnt <= '0;
    end else if (strobe.clrWindow) begin
      sinceCnt <= '0;
    end else if (tickLive && (sinceCnt < GAP_Q)) begin
      sinceCnt <= sinceCnt + 1'b1;
    end
  end

  assign lateHit  = wrapTick && (ovfTally == TALLY_LAST);
  assign gapShort = (sinceCnt < GAP_Q);

endmodule

// File: rtl/wdw_control.sv
module wdw_control
  import wdw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        serviceWr,
  input  logic        lateHit,
  input  logic        gapShort,
  output wdw_strobe_t strobe,
  output logic        alarmQ,
  output logic        earlyQ
);

  logic svcSeen;
  logic legalSvc;
  logic earlyFault;
  logic lateFault;

  assign legalSvc   = serviceWr && !alarmQ && (!svcSeen || !gapShort);
  assign earlyFault = serviceWr && !alarmQ && svcSeen && gapShort;
  // A service in the same cycle either clears the window or faults early
  assign lateFault  = lateHit && !alarmQ && !serviceWr;

  assign strobe.clrWindow = legalSvc;
  assign strobe.holdCount = alarmQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcSeen <= 1'b0;
      alarmQ  <= 1'b0;
      earlyQ  <= 1'b0;
    end else begin
      if (legalSvc) begin
        svcSeen <= 1'b1;
      end
      if (earlyFault) begin
        alarmQ <= 1'b1;
        earlyQ <= 1'b1;
      end else if (lateFault) begin
        alarmQ <= 1'b1;
        earlyQ <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wdw_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MIN_GAP   = 4096,
  parameter int OVF_LIMIT = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic serviceWr,
  input  logic cntEn,
  output logic alarmDrvLow,
  output logic faultIsEarly
);

  wdw_strobe_t strobe;
  logic        lateHit;
  logic        gapShort;
  logic        alarmQ;
  logic        earlyQ;

  wdw_datapath #(
    .CNT_W    (CNT_W),
    .MIN_GAP  (MIN_GAP),
    .OVF_LIMIT(OVF_LIMIT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cntEn   (cntEn),
    .strobe  (strobe),
    .lateHit (lateHit),
    .gapShort(gapShort)
  );

  wdw_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .serviceWr(serviceWr),
    .lateHit  (lateHit),
    .gapShort (gapShort),
    .strobe   (strobe),
    .alarmQ   (alarmQ),
    .earlyQ   (earlyQ)
  );

  assign alarmDrvLow  = alarmQ;
  assign faultIsEarly = earlyQ;

endmodule

// File: rtl/window_watchdog_chk.sv
module window_watchdog_chk (
  input logic clk,
  input logic rstN,
  input logic serviceWr,
  input logic cntEn,
  input logic alarmDrvLow,
  input logic faultIsEarly
);

  // R7: alarm latches until reset
  a_r7_alarm_latched: assert property (@(posedge clk) disable iff (!rstN)
    alarmDrvLow |=> alarmDrvLow);

  // R7: cause bit frozen while alarm is on
  a_r7_status_frozen: assert property (@(posedge clk) disable iff (!rstN)
    alarmDrvLow |=> $stable(faultIsEarly));

  // R4: early cause only comes with the alarm
  a_r4_early_implies_alarm: assert property (@(posedge clk) disable iff (!rstN)
    faultIsEarly |-> alarmDrvLow);

  // R4: an early fault needs a service write in the cycle before
  a_r4_early_needs_service: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(alarmDrvLow) && faultIsEarly) |-> $past(serviceWr));

  // R3: a late fault needs a tick and no service in the cycle before
  a_r3_late_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(alarmDrvLow) && !faultIsEarly) |-> ($past(cntEn) && !$past(serviceWr)));

endmodule

bind window_watchdog window_watchdog_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .serviceWr   (serviceWr),
  .cntEn       (cntEn),
  .alarmDrvLow (alarmDrvLow),
  .faultIsEarly(faultIsEarly)
);

// File: tb/tb_window_watchdog.sv
module tb_window_watchdog;

  localparam int CNT_W     = 4;
  localparam int MIN_GAP   = 6;
  localparam int OVF_LIMIT = 2;

  // op: 0 reset, 1 idle n cycles, 2 tick n cycles, 3 service, 4 service+tick
  typedef struct packed {
    int op;
    int n;
    bit expA;
    bit expE;
    int req;
  } vec_t;

  localparam int NVEC = 37;
  localparam vec_t VEC [NVEC] = '{
    // Seq A: first service, boundary, early fault, latch (R1 R5 R2 R8 R4 R7)
    '{0, 0, 1'b0, 1'b0, 1},
    '{3, 1, 1'b0, 1'b0, 5},
    '{2, 3, 1'b0, 1'b0, 2},
    '{1, 20, 1'b0, 1'b0, 8},
    '{2, 3, 1'b0, 1'b0, 2},
    '{3, 1, 1'b0, 1'b0, 4},   // exactly MIN_GAP ticks: accepted
    '{2, 5, 1'b0, 1'b0, 2},
    '{3, 1, 1'b1, 1'b1, 4},   // 5 ticks: early
    '{2, 40, 1'b1, 1'b1, 7},
    '{3, 1, 1'b1, 1'b1, 7},
    // Seq B: late fault from reset (R3 R7)
    '{0, 0, 1'b0, 1'b0, 1},
    '{2, 31, 1'b0, 1'b0, 3},
    '{2, 1, 1'b1, 1'b0, 3},
    '{3, 1, 1'b1, 1'b0, 7},
    // Seq C: late window follows counter phase at service (R5 R6 R3)
    '{0, 0, 1'b0, 1'b0, 1},
    '{2, 10, 1'b0, 1'b0, 2},
    '{3, 1, 1'b0, 1'b0, 5},
    '{2, 21, 1'b0, 1'b0, 6},
    '{2, 1, 1'b1, 1'b0, 3},
    // Seq D: services clear the tally (R6 R3)
    '{0, 0, 1'b0, 1'b0, 1},
    '{2, 20, 1'b0, 1'b0, 2},
    '{3, 1, 1'b0, 1'b0, 5},
    '{2, 20, 1'b0, 1'b0, 6},
    '{3, 1, 1'b0, 1'b0, 6},
    '{2, 23, 1'b0, 1'b0, 6},
    '{2, 1, 1'b1, 1'b0, 3},
    // Seq E: concurrent tick not counted (R6)
    '{0, 0, 1'b0, 1'b0, 1},
    '{4, 1, 1'b0, 1'b0, 6},
    '{2, 5, 1'b0, 1'b0, 2},
    '{3, 1, 1'b1, 1'b1, 6},
    // Seq F: idle cycles do not count (R8)
    '{0, 0, 1'b0, 1'b0, 1},
    '{3, 1, 1'b0, 1'b0, 5},
    '{1, 30, 1'b0, 1'b0, 8},
    '{2, 5, 1'b0, 1'b0, 8},
    '{3, 1, 1'b1, 1'b1, 8},
    // Seq G: overflow together with a service is cleared (R6)
    '{0, 0, 1'b0, 1'b0, 1},
    '{2, 31, 1'b0, 1'b0, 3}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serviceWr = 1'b0;
  logic cntEn = 1'b0;
  logic alarmDrvLow;
  logic faultIsEarly;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  window_watchdog #(
    .CNT_W    (CNT_W),
    .MIN_GAP  (MIN_GAP),
    .OVF_LIMIT(OVF_LIMIT)
  ) dut (
    .clk         (clk),
    .rstN        (rstN),
    .serviceWr   (serviceWr),
    .cntEn       (cntEn),
    .alarmDrvLow (alarmDrvLow),
    .faultIsEarly(faultIsEarly)
  );

  task automatic cyc(input logic s, input logic e);
    serviceWr = s;
    cntEn = e;
    @(negedge clk);
    serviceWr = 1'b0;
    cntEn = 1'b0;
  endtask

  task automatic runOp(input int op, input int n);
    case (op)
      0: begin
        rstN = 1'b0;
        repeat (2) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
      end
      1: repeat (n) cyc(1'b0, 1'b0);
      2: repeat (n) cyc(1'b0, 1'b1);
      3: cyc(1'b1, 1'b0);
      default: cyc(1'b1, 1'b1);
    endcase
  endtask

  task automatic check(input bit expA, input bit expE, input int req, input string what);
    checkCnt++;
    if (alarmDrvLow !== expA || faultIsEarly !== expE) begin
      failCnt++;
      $display("FAIL R%0d %s: alarm=%b early=%b expected alarm=%b early=%b",
               req, what, alarmDrvLow, faultIsEarly, expA, expE);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: run hung, alarm=%b expected completion", alarmDrvLow);
      finishRun();
    end
  end

  initial begin
    @(negedge clk);
    check(1'b0, 1'b0, 1, "R1 outputs during reset");

    for (int i = 0; i < NVEC; i++) begin
      runOp(VEC[i].op, VEC[i].n);
      check(VEC[i].expA, VEC[i].expE, VEC[i].req, $sformatf("vector %0d", i));
    end

    // Seq G continued, R6: service+tick on the second overflow edge
    runOp(4, 1);
    check(1'b0, 1'b0, 6, "R6 overflow with service cleared");
    runOp(2, 31);
    check(1'b0, 1'b0, 6, "R6 window restarted at phase 0");
    runOp(2, 1);
    check(1'b1, 1'b0, 3, "R3 second overflow after restart");

    // R1: reset during a latched alarm clears it at once
    rstN = 1'b0;
    #1;
    check(1'b0, 1'b0, 1, "R1 async reset clears alarm");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset clears the overflow tally
    runOp(2, 31);
    check(1'b0, 1'b0, 1, "R1 tally one below limit");
    runOp(0, 0);
    runOp(2, 31);
    check(1'b0, 1'b0, 1, "R1 reset cleared tally");
    runOp(2, 1);
    check(1'b1, 1'b0, 3, "R3 late after reset");

    // R4: one tick short of MIN_GAP after an accepted service
    runOp(0, 0);
    runOp(3, 1);
    runOp(2, MIN_GAP);
    runOp(3, 1);
    check(1'b0, 1'b0, 4, "R4 service at MIN_GAP accepted");
    runOp(2, MIN_GAP - 1);
    runOp(3, 1);
    check(1'b1, 1'b1, 4, "R4 service at MIN_GAP-1 early");

    // R5: first service right after reset with no ticks is legal
    runOp(0, 0);
    runOp(3, 1);
    check(1'b0, 1'b0, 5, "R5 immediate first service");

    done = 1'b1;
    finishRun();
  end

endmodule